// File: doc/BRIEF.md
# External Timestamp Capture Unit

This block records the current 64-bit time whenever one of several external trigger inputs rises. Each trigger passes through a two-flop synchronizer. A rising edge seen on an enabled channel copies the time input into that channel's capture store and raises the channel's event flag. A one-cycle pulse from the neighbouring pulse-per-second generator raises a further event flag in the same register, so one interrupt line serves all sources.

Software reads a timestamp as a low word and then a high word. Reading the high word pops the entry. In queue mode each channel holds up to four entries, and its valid flag stays set until the last one is popped. Outside queue mode a channel keeps only its latest capture. Event flags are cleared by writing ones. The interrupt asserts while any event flag is set whose mask bit is also set. Writing zero to the control and mask registers shuts the block down.

Top module: `tstamp_capture`

## Requirements
- R1: After reset, and after any later reset, these all read zero: control (address 0), event (address 1), mask (address 2) and status (address 3). `irq_o` is low.
- R2: With control bit c set, one rising edge on `trig_i[c]` produces exactly one capture of `time_i`. It sets event bit c and status bit c (valid). A held high level or a falling edge captures nothing more.
- R3: While control bit c is clear, edges on `trig_i[c]` capture nothing and set no event bit.
- R4: Control bit 2 selects queue mode, in which captures are kept in arrival order. Address 4+2c reads the low 32 bits of channel c's oldest entry and address 5+2c reads the high 32 bits. A read of the high word pops the entry. Status bit c stays set until the last entry is popped.
- R5: In queue mode a capture that arrives while four entries are held is dropped. It sets sticky status bit 2+c, which is cleared only by writing 1 to that bit of the status register.
- R6: With control bit 2 clear, a new capture replaces the held one, and the channel holds at most one entry.
- R7: Writing 1 to an event bit clears it, while writing 0 leaves it unchanged. If a source raises a bit in the same cycle that software clears it, the bit stays set.
- R8: `irq_o` is high exactly when the bitwise AND of the event register and the mask register (address 2) is nonzero.
- R9: A pulse on `pps_pulse_i` sets event bit 2. It drives the interrupt through mask bit 2.
- R10: With the channel empty, reads of its timestamp addresses return zero. A high-word read then changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| time_i | input | 64 | Current time from the time counter |
| trig_i | input | 2 | Asynchronous external trigger inputs, one per channel |
| pps_pulse_i | input | 1 | One-cycle pulse from the pulse-per-second generator |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (high-word reads pop) |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| irq_o | output | 1 | Interrupt request |

## Verification
Captures are driven in four patterns, and each pattern separates one behaviour from another:
- A trigger on a disabled channel separates gating from edge detection.
- Repeated triggers in single mode separate overwrite from queueing.
- Two triggers on the second channel in queue mode confirm arrival order and the persistence of the valid flag.
- Five back-to-back triggers against a depth of four show that the newest capture, and not the oldest, is dropped, and that the overflow flag is sticky.

A trigger held high for many cycles and then released separates edge detection from level sensing. Event-register writes of zeros, writes of ones, and a clear that coincides with a new pulse show the clear semantics and which side wins a collision.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int unsigned REG_AW = 4;
  localparam int unsigned REG_DW = 32;

  localparam logic [REG_AW-1:0] ADR_CTRL  = 4'd0;
  localparam logic [REG_AW-1:0] ADR_EVT   = 4'd1;
  localparam logic [REG_AW-1:0] ADR_MASK  = 4'd2;
  localparam logic [REG_AW-1:0] ADR_STAT  = 4'd3;
  localparam int unsigned       ADR_TS0   = 4;
endpackage

// File: rtl/tsc_edge_sync.sv
module tsc_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [2:0] sh_q;
  logic [2:0] sh_n;

  always_comb begin
    sh_n = {sh_q[1:0], async_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_n;
  end

  assign rise_o = sh_q[1] & ~sh_q[2];

  // R2
  single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tsc_stamp_queue.sv
module tsc_stamp_queue #(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [TIME_W-1:0] stamp_i,
  input  logic              queue_mode_i,
  input  logic              pop_i,
  input  logic              ovf_clr_i,
  output logic [TIME_W-1:0] head_o,
  output logic              valid_o,
  output logic              ovf_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  logic [TIME_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0]  rd_q, rd_n, wr_q, wr_n, wr_slot;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              ovf_q, ovf_n, ovf_set;
  logic              wr_en, do_pop, full;

  always_comb begin
    do_pop  = pop_i && (cnt_q != '0);
    full    = (cnt_q == FULL_CNT);
    rd_n    = do_pop ? ptr_inc(rd_q) : rd_q;
    wr_n    = wr_q;
    cnt_n   = do_pop ? cnt_q - 1'b1 : cnt_q;
    wr_en   = 1'b0;
    wr_slot = wr_q;
    ovf_set = 1'b0;
    if (push_i) begin
      if (!queue_mode_i) begin
        wr_en   = 1'b1;
        wr_slot = rd_n;
        wr_n    = ptr_inc(rd_n);
        cnt_n   = CNT_W'(1);
      end else if (!full || do_pop) begin
        wr_en   = 1'b1;
        wr_slot = wr_q;
        wr_n    = ptr_inc(wr_q);
        cnt_n   = do_pop ? cnt_q : cnt_q + 1'b1;
      end else begin
        ovf_set = 1'b1;
      end
    end
    ovf_n = (ovf_q & ~ovf_clr_i) | ovf_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      cnt_q <= cnt_n;
      ovf_q <= ovf_n;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              slot_q[i] <= '0;
      else if (wr_en && (wr_slot == PTR_W'(i))) slot_q[i] <= stamp_i;
    end
  end

  assign valid_o = (cnt_q != '0);
  assign head_o  = valid_o ? slot_q[rd_q] : '0;
  assign ovf_o   = ovf_q;

  // R4
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT);
  // R5
  ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(push_i && queue_mode_i && full && !do_pop));
  // R6
  single_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !queue_mode_i) |=> (cnt_q == CNT_W'(1)));
  // R10
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !valid_o && !push_i) |=> !valid_o);
endmodule

// File: rtl/tsc_event_regs.sv
module tsc_event_regs #(
  parameter int unsigned NSRC = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic            evt_we_i,
  input  logic            mask_we_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] evt_o,
  output logic [NSRC-1:0] mask_o,
  output logic            irq_o
);
  logic [NSRC-1:0] evt_q, evt_n, mask_q, mask_n, clr;

  always_comb begin
    clr    = evt_we_i ? wdata_i : '0;
    evt_n  = (evt_q & ~clr) | set_i;
    mask_n = mask_we_i ? wdata_i : mask_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q  <= '0;
      mask_q <= '0;
    end else begin
      evt_q  <= evt_n;
      mask_q <= mask_n;
    end
  end

  assign evt_o  = evt_q;
  assign mask_o = mask_q;
  assign irq_o  = |(evt_q & mask_q);

  // R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((evt_q & $past(set_i)) == $past(set_i)));
  // R7
  no_spurious_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q & ~$past(evt_q) & ~$past(set_i)) == '0);
endmodule

// File: rtl/tstamp_capture.sv
module tstamp_capture
  import tsc_pkg::*;
#(
  parameter int unsigned NCH    = 2,
  parameter int unsigned TIME_W = 64,
  parameter int unsigned QDEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] time_i,
  input  logic [NCH-1:0]    trig_i,
  input  logic              pps_pulse_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned NSRC   = NCH + 1;
  localparam int unsigned CTRL_W = NCH + 1;
  localparam int unsigned QM_BIT = NCH;
  localparam int unsigned STAT_W = 2 * NCH;

  logic [CTRL_W-1:0] ctrl_q, ctrl_n;
  logic              ctrl_we, evt_we, mask_we, stat_we;
  logic [NCH-1:0]    rise, push, pop, valid, ovf, ovf_clr;
  logic [TIME_W-1:0] head [NCH];
  logic [NSRC-1:0]   evt_set, evt, mask;

  always_comb begin
    ctrl_we = reg_wr_i && (reg_addr_i == ADR_CTRL);
    evt_we  = reg_wr_i && (reg_addr_i == ADR_EVT);
    mask_we = reg_wr_i && (reg_addr_i == ADR_MASK);
    stat_we = reg_wr_i && (reg_addr_i == ADR_STAT);
    ctrl_n  = ctrl_we ? reg_wdata_i[CTRL_W-1:0] : ctrl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_n;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [REG_AW-1:0] HI_ADR = REG_AW'(ADR_TS0 + 2 * c + 1);

    tsc_edge_sync u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(trig_i[c]),
      .rise_o (rise[c])
    );

    assign push[c]    = rise[c] & ctrl_q[c];
    assign pop[c]     = reg_rd_i && (reg_addr_i == HI_ADR);
    assign ovf_clr[c] = stat_we && reg_wdata_i[NCH + c];

    tsc_stamp_queue #(.TIME_W(TIME_W), .DEPTH(QDEPTH)) u_queue (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (push[c]),
      .stamp_i     (time_i),
      .queue_mode_i(ctrl_q[QM_BIT]),
      .pop_i       (pop[c]),
      .ovf_clr_i   (ovf_clr[c]),
      .head_o      (head[c]),
      .valid_o     (valid[c]),
      .ovf_o       (ovf[c])
    );
  end

  assign evt_set = {pps_pulse_i, push};

  tsc_event_regs #(.NSRC(NSRC)) u_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (evt_set),
    .evt_we_i (evt_we),
    .mask_we_i(mask_we),
    .wdata_i  (reg_wdata_i[NSRC-1:0]),
    .evt_o    (evt),
    .mask_o   (mask),
    .irq_o    (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADR_CTRL)      reg_rdata_o = REG_DW'(ctrl_q);
    else if (reg_addr_i == ADR_EVT)  reg_rdata_o = REG_DW'(evt);
    else if (reg_addr_i == ADR_MASK) reg_rdata_o = REG_DW'(mask);
    else if (reg_addr_i == ADR_STAT) reg_rdata_o = REG_DW'({ovf, valid});
    else begin
      for (int c = 0; c < NCH; c++) begin
        if (reg_addr_i == REG_AW'(ADR_TS0 + 2 * c))
          reg_rdata_o = head[c][REG_DW-1:0];
        if (reg_addr_i == REG_AW'(ADR_TS0 + 2 * c + 1))
          reg_rdata_o = REG_DW'(head[c] >> REG_DW);
      end
    end
  end

  // R3
  gated_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ctrl_q[NCH-1:0] == '0) && !pps_pulse_i && !evt_we) |=> $stable(evt));
  // R8
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> !irq_o);

  localparam int unsigned UNUSED_STAT_W = STAT_W;
endmodule

// File: tb/tb_tstamp_capture.sv
module tb_tstamp_capture;
  localparam logic [2:0] OP_RD = 3'd0, OP_WR = 3'd1, OP_TRG = 3'd2,
                         OP_PPS = 3'd3, OP_IRQ = 3'd4;
  localparam logic [3:0] A_CT = 4'd0, A_EV = 4'd1, A_MK = 4'd2, A_ST = 4'd3,
                         A_L0 = 4'd4, A_H0 = 4'd5, A_L1 = 4'd6, A_H1 = 4'd7;

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  addr;
    logic [63:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 61;
  localparam vec_t VECS [NV] = '{
    '{OP_RD,  A_ST, 64'h0, 32'h0, 4'd1},              // R1
    '{OP_RD,  A_EV, 64'h0, 32'h0, 4'd1},              // R1
    '{OP_IRQ, A_CT, 64'h0, 32'h0, 4'd1},              // R1
    '{OP_TRG, 4'd0, 64'h100, 32'h0, 4'd3},            // R3 disabled trigger
    '{OP_RD,  A_EV, 64'h0, 32'h0, 4'd3},              // R3
    '{OP_RD,  A_ST, 64'h0, 32'h0, 4'd3},              // R3
    '{OP_WR,  A_CT, 64'h1, 32'h0, 4'd0},
    '{OP_TRG, 4'd0, 64'h1111_2222_3333_4444, 32'h0, 4'd2},
    '{OP_RD,  A_EV, 64'h0, 32'h1, 4'd2},              // R2
    '{OP_RD,  A_ST, 64'h0, 32'h1, 4'd2},              // R2
    '{OP_TRG, 4'd0, 64'hAA, 32'h0, 4'd6},
    '{OP_RD,  A_ST, 64'h0, 32'h1, 4'd6},              // R6
    '{OP_RD,  A_L0, 64'h0, 32'hAA, 4'd6},             // R6 latest kept
    '{OP_RD,  A_H0, 64'h0, 32'h0, 4'd6},              // R6
    '{OP_RD,  A_ST, 64'h0, 32'h0, 4'd6},              // R6 single entry
    '{OP_RD,  A_L0, 64'h0, 32'h0, 4'd10},             // R10
    '{OP_RD,  A_H0, 64'h0, 32'h0, 4'd10},             // R10
    '{OP_RD,  A_ST, 64'h0, 32'h0, 4'd10},             // R10
    '{OP_IRQ, A_CT, 64'h0, 32'h0, 4'd8},              // R8
    '{OP_WR,  A_MK, 64'h1, 32'h0, 4'd0},
    '{OP_IRQ, A_CT, 64'h0, 32'h1, 4'd8},              // R8
    '{OP_WR,  A_EV, 64'h0, 32'h0, 4'd0},
    '{OP_RD,  A_EV, 64'h0, 32'h1, 4'd7},              // R7 zero write
    '{OP_WR,  A_EV, 64'h1, 32'h0, 4'd0},
    '{OP_RD,  A_EV, 64'h0, 32'h0, 4'd7},              // R7 one clears
    '{OP_IRQ, A_CT, 64'h0, 32'h0, 4'd8},              // R8
    '{OP_WR,  A_CT, 64'h7, 32'h0, 4'd0},
    '{OP_TRG, 4'd1, 64'h5_0000_0001, 32'h0, 4'd4},
    '{OP_TRG, 4'd1, 64'h6_0000_0002, 32'h0, 4'd4},
    '{OP_RD,  A_ST, 64'h0, 32'h2, 4'd4},              // R4
    '{OP_RD,  A_L1, 64'h0, 32'h1, 4'd4},              // R4
    '{OP_RD,  A_H1, 64'h0, 32'h5, 4'd4},              // R4
    '{OP_RD,  A_ST, 64'h0, 32'h2, 4'd4},              // R4 still valid
    '{OP_RD,  A_L1, 64'h0, 32'h2, 4'd4},              // R4
    '{OP_RD,  A_H1, 64'h0, 32'h6, 4'd4},              // R4
    '{OP_RD,  A_ST, 64'h0, 32'h0, 4'd4},              // R4
    '{OP_RD,  A_EV, 64'h0, 32'h2, 4'd2},              // R2
    '{OP_IRQ, A_CT, 64'h0, 32'h0, 4'd8},              // R8
    '{OP_PPS, A_CT, 64'h0, 32'h0, 4'd9},
    '{OP_RD,  A_EV, 64'h0, 32'h6, 4'd9},              // R9
    '{OP_WR,  A_MK, 64'h4, 32'h0, 4'd0},
    '{OP_IRQ, A_CT, 64'h0, 32'h1, 4'd9},              // R9
    '{OP_WR,  A_EV, 64'h6, 32'h0, 4'd0},
    '{OP_IRQ, A_CT, 64'h0, 32'h0, 4'd8},              // R8
    '{OP_TRG, 4'd0, 64'h10, 32'h0, 4'd5},
    '{OP_TRG, 4'd0, 64'h11, 32'h0, 4'd5},
    '{OP_TRG, 4'd0, 64'h12, 32'h0, 4'd5},
    '{OP_TRG, 4'd0, 64'h13, 32'h0, 4'd5},
    '{OP_TRG, 4'd0, 64'h14, 32'h0, 4'd5},
    '{OP_RD,  A_ST, 64'h0, 32'h5, 4'd5},              // R5 valid + overflow
    '{OP_RD,  A_L0, 64'h0, 32'h10, 4'd5},             // R5 oldest kept
    '{OP_RD,  A_H0, 64'h0, 32'h0, 4'd5},
    '{OP_RD,  A_L0, 64'h0, 32'h11, 4'd5},
    '{OP_RD,  A_H0, 64'h0, 32'h0, 4'd5},
    '{OP_RD,  A_L0, 64'h0, 32'h12, 4'd5},
    '{OP_RD,  A_H0, 64'h0, 32'h0, 4'd5},
    '{OP_RD,  A_L0, 64'h0, 32'h13, 4'd5},             // R5 newest dropped
    '{OP_RD,  A_H0, 64'h0, 32'h0, 4'd5},
    '{OP_RD,  A_ST, 64'h0, 32'h4, 4'd5},              // R5 sticky
    '{OP_WR,  A_ST, 64'h4, 32'h0, 4'd0},
    '{OP_RD,  A_ST, 64'h0, 32'h0, 4'd5}               // R5 cleared
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] time_v;
  logic [1:0]  trig;
  logic        pps;
  logic        wr, rd;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  tstamp_capture dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .time_i     (time_v),
    .trig_i     (trig),
    .pps_pulse_i(pps),
    .reg_wr_i   (wr),
    .reg_rd_i   (rd),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .irq_o      (irq)
  );

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, input logic [31:0] exp, input int req);
    addr = a; rd = 1'b1;
    #1 check(req, rdata, exp);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic trigger(input int ch, input logic [63:0] t);
    time_v = t;
    trig[ch] = 1'b1;
    repeat (3) @(negedge clk);
    trig[ch] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1: watchdog expired, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; time_v = '0; trig = '0; pps = 1'b0;
    wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_RD:  reg_read(VECS[i].addr, VECS[i].exp, int'(VECS[i].req));
        OP_WR:  reg_write(VECS[i].addr, VECS[i].data[31:0]);
        OP_TRG: trigger(int'(VECS[i].addr), VECS[i].data);
        OP_PPS: begin
          pps = 1'b1;
          @(negedge clk);
          pps = 1'b0;
        end
        default: #1 check(int'(VECS[i].req), {31'b0, irq}, VECS[i].exp);
      endcase
    end

    // R7: a clear colliding with a new pulse leaves the bit set
    reg_write(A_EV, 32'h7);
    reg_read(A_EV, 32'h0, 7);
    pps = 1'b1; addr = A_EV; wdata = 32'h4; wr = 1'b1;
    @(negedge clk);
    pps = 1'b0; wr = 1'b0;
    reg_read(A_EV, 32'h4, 7);

    // R1: reset in mid operation
    trigger(0, 64'h77);
    reg_read(A_ST, 32'h1, 2);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reg_read(A_ST, 32'h0, 1);
    reg_read(A_EV, 32'h0, 1);
    reg_read(A_CT, 32'h0, 1);
    reg_read(A_MK, 32'h0, 1);
    #1 check(1, {31'b0, irq}, 32'h0);

    // R2: a long high level and its falling edge give one capture only
    reg_write(A_CT, 32'h5);
    time_v = 64'h33;
    trig[0] = 1'b1;
    repeat (10) @(negedge clk);
    reg_read(A_ST, 32'h1, 2);
    reg_read(A_L0, 32'h33, 2);
    reg_read(A_H0, 32'h0, 2);
    reg_read(A_ST, 32'h0, 2);
    trig[0] = 1'b0;
    repeat (5) @(negedge clk);
    reg_read(A_ST, 32'h0, 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule